// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block folds seventeen level-sensitive interrupt lines and a handful of bus-controller event sources into a single upstream interrupt request. It does so through two register banks in cascade. The first bank lives beside the bus host controller. Every source sets a sticky bit in its status register. When a global enable is on, the bank's masked summary drives one input bit of the second bank. The second bank is a bus-master interrupt unit. It latches its input bits, qualified by its own mask, into a second sticky status register, and the upstream request is raised while that register holds any set bit.

Software reaches both banks through one 32-bit register port. A bank-select input picks the bank and an 8-bit byte offset picks the register. Reads are combinational and have no side effects. Both status registers clear only when software writes ones to them. A polarity register and two routing registers in the master bank are kept for software but do not change behaviour. Decoding the serial interrupt frame is done outside this block: it receives the lines already decoded as levels.

Top module: `irq_cascade_top`

## Requirements
- R1: Register map. With bank 0 selected: fast-read size 0x28, control 0x30, mask 0x34, status 0x38, error address 0x40. With bank 1 selected: route0 0x08, route1 0x0C, status 0x50, mask 0x54, polarity 0x58, input 0x5C. The size, control, mask, route and polarity registers store a full 32-bit write and read it back unchanged.
- R2: After reset the fast-read size register reads 0x0200_0000 (bit 25 set), every other register reads zero, and irq_o is low.
- R3: A high level on line_i[n] at a rising clock edge sets bank 0 status bit 31-n on that edge. A low level clears nothing.
- R4: evt_i[8] sets bank 0 status bit 10, and evt_i[7:0] set bank 0 status bits 7..0. These bits are sticky in the same way as the line bits.
- R5: A write to bank 0 status clears each bit written as 1. If a source asserts a bit in the same cycle as the write that clears it, the bit stays set.
- R6: Bank 1 input bit 11 reads 1 exactly when bank 0 control bit 31 is set and (bank 0 status AND bank 0 mask) is nonzero. All other input bits read 0.
- R7: On every clock edge, bank 1 status takes status OR (input AND bank 1 mask). A latched bit stays set after the input bit falls.
- R8: A write to bank 1 status clears each bit written as 1, with the same set-wins rule as R5. irq_o is high exactly while bank 1 status is nonzero.
- R9: The polarity register stores its value but has no effect on latching or on irq_o.
- R10: Reads of unmapped offsets in either bank return 0xFFFF_FFFF, and writes to them change nothing. The error address register always reads 0, and writes to it or to the input register have no effect.
- R11: Reading either status register does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access valid this cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_bank_i | input | 1 | 0 = host-controller bank, 1 = master bank |
| reg_addr_i | input | 8 | Byte offset within the selected bank |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from bank and offset |
| line_i | input | 17 | Level interrupt lines 0..16 |
| evt_i | input | 9 | Controller event sources: bit 8 is reset-seen, bits 7..0 are sync, turnaround and request events |
| irq_o | output | 1 | Upstream interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a status bit being set and cleared in the same cycle. The stimulus holds a line high across the clear write to bank 0 status and then checks that the bit survived. The second is the master latch outliving its cause. The stimulus first raises the summary while the master mask is still zero, so nothing may latch. It then opens the mask, lets the bit latch, and clears the first bank underneath it. irq_o must stay high until bank 1 status is written directly. A behavioural model tracks both banks on every clock and covers every read and irq_o value along the way.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

  localparam int unsigned REG_W = 32;
  localparam int unsigned OFS_W = 8;

  typedef logic [OFS_W-1:0] ofs_t;
  typedef logic [REG_W-1:0] word_t;

  // host-controller bank (bank select 0)
  localparam ofs_t HC_FWSIZE  = 8'h28;
  localparam ofs_t HC_CTRL    = 8'h30;
  localparam ofs_t HC_MASK    = 8'h34;
  localparam ofs_t HC_STAT    = 8'h38;
  localparam ofs_t HC_ERRADDR = 8'h40;

  // master bank (bank select 1)
  localparam ofs_t MB_ROUTE0 = 8'h08;
  localparam ofs_t MB_ROUTE1 = 8'h0C;
  localparam ofs_t MB_STAT   = 8'h50;
  localparam ofs_t MB_MASK   = 8'h54;
  localparam ofs_t MB_POL    = 8'h58;
  localparam ofs_t MB_INPUT  = 8'h5C;

  localparam int unsigned HC_EN_BIT   = 31;
  localparam int unsigned HC_LRST_BIT = 10;
  localparam int unsigned MB_SRC_BIT  = 11;

  localparam word_t HC_FWSIZE_RST = 32'h0200_0000;
  localparam word_t UNMAPPED_RD   = '1;

endpackage

// File: rtl/irq_host_bank.sv
module irq_host_bank
  import irq_cascade_pkg::*;
#(
  parameter int unsigned NUM_LINES = 17,
  parameter int unsigned EVT_W     = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_i,
  input  logic                 wr_i,
  input  ofs_t                 addr_i,
  input  word_t                wdata_i,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [EVT_W-1:0]     evt_i,
  output word_t                rdata_o,
  output word_t                stat_o,
  output logic                 en_o,
  output logic                 sum_o
);

  localparam int unsigned LINE_LSB = REG_W - NUM_LINES;
  localparam int unsigned LOW_EVT  = EVT_W - 1;

  word_t ctrl_q, mask_q, stat_q, size_q;
  word_t set_vec, clr_vec, stat_d;
  logic  wr_ctrl, wr_mask, wr_stat, wr_size;

  assign wr_ctrl = acc_i & wr_i & (addr_i == HC_CTRL);
  assign wr_mask = acc_i & wr_i & (addr_i == HC_MASK);
  assign wr_stat = acc_i & wr_i & (addr_i == HC_STAT);
  assign wr_size = acc_i & wr_i & (addr_i == HC_FWSIZE);

  // line n lands on bit 31-n; events fill reset-seen and the low byte
  for (genvar b = 0; b < REG_W; b++) begin : g_set
    if (b >= LINE_LSB) begin : g_line
      assign set_vec[b] = line_i[REG_W-1-b];
    end else if (b == HC_LRST_BIT) begin : g_lrst
      assign set_vec[b] = evt_i[EVT_W-1];
    end else if (b < LOW_EVT) begin : g_evt
      assign set_vec[b] = evt_i[b];
    end else begin : g_none
      assign set_vec[b] = 1'b0;
    end
  end

  assign clr_vec = wr_stat ? wdata_i : '0;
  assign stat_d  = (stat_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
      size_q <= HC_FWSIZE_RST;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i;
      if (wr_mask) mask_q <= wdata_i;
      if (wr_size) size_q <= wdata_i;
      stat_q <= stat_d;
    end
  end

  assign en_o   = ctrl_q[HC_EN_BIT];
  assign sum_o  = en_o & (|(stat_q & mask_q));
  assign stat_o = stat_q;

  always_comb begin
    case (addr_i)
      HC_FWSIZE:  rdata_o = size_q;
      HC_CTRL:    rdata_o = ctrl_q;
      HC_MASK:    rdata_o = mask_q;
      HC_STAT:    rdata_o = stat_q;
      HC_ERRADDR: rdata_o = '0;
      default:    rdata_o = UNMAPPED_RD;
    endcase
  end

endmodule

// File: rtl/irq_master_bank.sv
module irq_master_bank
  import irq_cascade_pkg::*;
#(
  parameter int unsigned SRC_BIT = MB_SRC_BIT
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  acc_i,
  input  logic  wr_i,
  input  ofs_t  addr_i,
  input  word_t wdata_i,
  input  logic  src_i,
  output word_t rdata_o,
  output word_t in_o,
  output word_t stat_o,
  output logic  irq_o
);

  word_t route0_q, route1_q, mask_q, pol_q, stat_q;
  word_t in_vec, clr_vec, stat_d;
  logic  wr_r0, wr_r1, wr_mask, wr_pol, wr_stat;

  assign wr_r0   = acc_i & wr_i & (addr_i == MB_ROUTE0);
  assign wr_r1   = acc_i & wr_i & (addr_i == MB_ROUTE1);
  assign wr_mask = acc_i & wr_i & (addr_i == MB_MASK);
  assign wr_pol  = acc_i & wr_i & (addr_i == MB_POL);
  assign wr_stat = acc_i & wr_i & (addr_i == MB_STAT);

  for (genvar b = 0; b < REG_W; b++) begin : g_in
    if (b == SRC_BIT) begin : g_src
      assign in_vec[b] = src_i;
    end else begin : g_zero
      assign in_vec[b] = 1'b0;
    end
  end

  assign clr_vec = wr_stat ? wdata_i : '0;
  assign stat_d  = (stat_q & ~clr_vec) | (in_vec & mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route0_q <= '0;
      route1_q <= '0;
      mask_q   <= '0;
      pol_q    <= '0;
      stat_q   <= '0;
    end else begin
      if (wr_r0)   route0_q <= wdata_i;
      if (wr_r1)   route1_q <= wdata_i;
      if (wr_mask) mask_q   <= wdata_i;
      if (wr_pol)  pol_q    <= wdata_i;
      stat_q <= stat_d;
    end
  end

  // polarity is kept for software only
  assign irq_o  = |stat_q;
  assign in_o   = in_vec;
  assign stat_o = stat_q;

  always_comb begin
    case (addr_i)
      MB_ROUTE0: rdata_o = route0_q;
      MB_ROUTE1: rdata_o = route1_q;
      MB_STAT:   rdata_o = stat_q;
      MB_MASK:   rdata_o = mask_q;
      MB_POL:    rdata_o = pol_q;
      MB_INPUT:  rdata_o = in_vec;
      default:   rdata_o = UNMAPPED_RD;
    endcase
  end

endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
  import irq_cascade_pkg::*;
#(
  parameter int unsigned NUM_LINES = 17,
  parameter int unsigned EVT_W     = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_valid_i,
  input  logic                 reg_write_i,
  input  logic                 reg_bank_i,
  input  logic [OFS_W-1:0]     reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [EVT_W-1:0]     evt_i,
  output logic                 irq_o
);

  logic  hc_acc, mb_acc;
  word_t hc_rdata, mb_rdata;
  word_t host_stat, mst_in, mst_stat;
  logic  host_en, host_sum;

  assign hc_acc = reg_valid_i & ~reg_bank_i;
  assign mb_acc = reg_valid_i &  reg_bank_i;

  irq_host_bank #(
    .NUM_LINES (NUM_LINES),
    .EVT_W     (EVT_W)
  ) u_host (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (hc_acc),
    .wr_i    (reg_write_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .line_i  (line_i),
    .evt_i   (evt_i),
    .rdata_o (hc_rdata),
    .stat_o  (host_stat),
    .en_o    (host_en),
    .sum_o   (host_sum)
  );

  irq_master_bank #(
    .SRC_BIT (MB_SRC_BIT)
  ) u_master (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (mb_acc),
    .wr_i    (reg_write_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .src_i   (host_sum),
    .rdata_o (mb_rdata),
    .in_o    (mst_in),
    .stat_o  (mst_stat),
    .irq_o   (irq_o)
  );

  assign reg_rdata_o = reg_bank_i ? mb_rdata : hc_rdata;

endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
#(
  parameter int unsigned NUM_LINES = 17,
  parameter int unsigned EVT_W     = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_valid_i,
  input logic                 reg_write_i,
  input logic                 reg_bank_i,
  input logic [OFS_W-1:0]     reg_addr_i,
  input logic [REG_W-1:0]     reg_wdata_i,
  input logic [NUM_LINES-1:0] line_i,
  input logic                 irq_o,
  input logic [REG_W-1:0]     host_stat,
  input logic                 host_en,
  input logic [REG_W-1:0]     mst_in,
  input logic [REG_W-1:0]     mst_stat
);

  logic hc_stat_wr, mb_stat_wr;
  assign hc_stat_wr = reg_valid_i & reg_write_i & ~reg_bank_i & (reg_addr_i == HC_STAT);
  assign mb_stat_wr = reg_valid_i & reg_write_i &  reg_bank_i & (reg_addr_i == MB_STAT);

  // R3: a high line is latched on that edge
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_ln
    a_r3_line_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_i[n] |=> host_stat[REG_W-1-n]);
  end

  a_r5_host_fall_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(host_stat) & ~host_stat)) |-> $past(hc_stat_wr));

  a_r6_input_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_in[MB_SRC_BIT] |-> host_en);

  a_r7_master_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_stat[MB_SRC_BIT] && !mb_stat_wr) |=> mst_stat[MB_SRC_BIT]);

  a_r8_irq_fall_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(mb_stat_wr));

endmodule

bind irq_cascade_top irq_cascade_chk #(
  .NUM_LINES (NUM_LINES),
  .EVT_W     (EVT_W)
) u_chk (.*);

// File: tb/tb_irq_cascade_top.sv
`timescale 1ns/1ps
module tb_irq_cascade_top;

  localparam int NL = 17;
  localparam int NE = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0, bank = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NL-1:0] line = '0;
  logic [NE-1:0] evt = '0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  irq_cascade_top dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_valid_i(valid), .reg_write_i(write),
    .reg_bank_i(bank), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .line_i(line), .evt_i(evt), .irq_o(irq)
  );

  always #4 clk = ~clk;

  // behavioural reference
  logic [31:0] m_ctrl = 0, m_hmask = 0, m_hstat = 0, m_size = 32'h0200_0000;
  logic [31:0] m_r0 = 0, m_r1 = 0, m_mstat = 0, m_mmask = 0, m_pol = 0;

  function automatic logic [31:0] m_input();
    return (m_ctrl[31] && ((m_hstat & m_hmask) != 0)) ? 32'h0000_0800 : 32'h0;
  endfunction

  function automatic logic [31:0] m_read(input logic b, input logic [7:0] a);
    if (!b) begin
      case (a)
        8'h28: return m_size;
        8'h30: return m_ctrl;
        8'h34: return m_hmask;
        8'h38: return m_hstat;
        8'h40: return 32'h0;
        default: return 32'hFFFF_FFFF;
      endcase
    end else begin
      case (a)
        8'h08: return m_r0;
        8'h0C: return m_r1;
        8'h50: return m_mstat;
        8'h54: return m_mmask;
        8'h58: return m_pol;
        8'h5C: return m_input();
        default: return 32'hFFFF_FFFF;
      endcase
    end
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] sv, ch, cm, nh, nm;
    logic wh, wm;
    if (!rst_n) begin
      m_ctrl = 0; m_hmask = 0; m_hstat = 0; m_size = 32'h0200_0000;
      m_r0 = 0; m_r1 = 0; m_mstat = 0; m_mmask = 0; m_pol = 0;
    end else begin
      sv = 0;
      for (int i = 0; i < NL; i++) if (line[i]) sv[31-i] = 1'b1;
      if (evt[8]) sv[10] = 1'b1;
      sv[7:0] = sv[7:0] | evt[7:0];
      wh = valid && write && !bank;
      wm = valid && write && bank;
      ch = (wh && addr == 8'h38) ? wdata : 32'h0;
      cm = (wm && addr == 8'h50) ? wdata : 32'h0;
      nh = (m_hstat & ~ch) | sv;
      nm = (m_mstat & ~cm) | (m_input() & m_mmask);
      if (wh) case (addr)
        8'h28: m_size = wdata;
        8'h30: m_ctrl = wdata;
        8'h34: m_hmask = wdata;
        default: ;
      endcase
      if (wm) case (addr)
        8'h08: m_r0 = wdata;
        8'h0C: m_r1 = wdata;
        8'h54: m_mmask = wdata;
        8'h58: m_pol = wdata;
        default: ;
      endcase
      m_hstat = nh;
      m_mstat = nm;
    end
  end

  always @(negedge clk) begin : compare
    logic [31:0] exp_rd;
    logic exp_irq;
    exp_rd  = m_read(bank, addr);
    exp_irq = (m_mstat != 0);
    n_cmp += 2;
    if (rdata !== exp_rd) begin
      n_bad++;
      $display("FAIL R1 model read bank %0d ofs %h: got %h expected %h", bank, addr, rdata, exp_rd);
    end
    if (irq !== exp_irq) begin
      n_bad++;
      $display("FAIL R8 model irq: got %0b expected %0b", irq, exp_irq);
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic b, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    valid = 1; write = 1; bank = b; addr = a; wdata = d;
    @(negedge clk); #1;
    valid = 0; write = 0;
  endtask

  task automatic rd(input string tag, input logic b, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); #1;
    valid = 1; write = 0; bank = b; addr = a;
    #1;
    check(tag, rdata, exp);
    valid = 0;
  endtask

  task automatic pulse(input logic [NL-1:0] l, input logic [NE-1:0] e);
    @(negedge clk); #1;
    line = l; evt = e;
    @(negedge clk); #1;
    line = '0; evt = '0;
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    @(negedge clk); #1;
    check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin : watchdog
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd("R2 size reset", 0, 8'h28, 32'h0200_0000);
    rd("R2 ctrl reset", 0, 8'h30, 32'h0);
    rd("R2 mstat reset", 1, 8'h50, 32'h0);
    irq_chk("R2 irq reset", 1'b0);

    wr(0, 8'h34, 32'h1234_5678); rd("R1 hmask", 0, 8'h34, 32'h1234_5678);
    wr(1, 8'h08, 32'hDEAD_BEEF); rd("R1 route0", 1, 8'h08, 32'hDEAD_BEEF);
    wr(1, 8'h0C, 32'h0BAD_F00D); rd("R1 route1", 1, 8'h0C, 32'h0BAD_F00D);
    wr(0, 8'h28, 32'h0000_0001); rd("R1 size", 0, 8'h28, 32'h0000_0001);

    pulse(17'h00001, '0); rd("R3 line0", 0, 8'h38, 32'h8000_0000);
    pulse(17'h10000, '0); rd("R3 line16", 0, 8'h38, 32'h8000_8000);
    rd("R11 read keeps status", 0, 8'h38, 32'h8000_8000);

    wr(0, 8'h38, 32'h8000_0000); rd("R5 partial clear", 0, 8'h38, 32'h0000_8000);
    wr(0, 8'h38, 32'hFFFF_FFFF); rd("R5 full clear", 0, 8'h38, 32'h0);
    @(negedge clk); #1; line = 17'h00004;
    wr(0, 8'h38, 32'h2000_0000);
    @(negedge clk); #1; line = '0;
    rd("R5 set wins", 0, 8'h38, 32'h2000_0000);
    wr(0, 8'h38, 32'hFFFF_FFFF);

    pulse('0, 9'h100); rd("R4 reset-seen bit10", 0, 8'h38, 32'h0000_0400);
    pulse('0, 9'h0A5); rd("R4 low events", 0, 8'h38, 32'h0000_04A5);
    wr(0, 8'h38, 32'hFFFF_FFFF);

    wr(0, 8'h34, 32'hFFFF_FFFF);
    pulse(17'h00008, '0); rd("R3 line3", 0, 8'h38, 32'h1000_0000);
    rd("R6 input off w/o enable", 1, 8'h5C, 32'h0);
    wr(0, 8'h30, 32'h8000_0000);
    rd("R6 input on", 1, 8'h5C, 32'h0000_0800);
    rd("R7 masked no latch", 1, 8'h50, 32'h0);
    irq_chk("R7 masked irq low", 1'b0);

    wr(1, 8'h54, 32'h0000_0800);
    rd("R7 latched", 1, 8'h50, 32'h0000_0800);
    irq_chk("R8 irq high", 1'b1);
    wr(0, 8'h38, 32'hFFFF_FFFF);
    rd("R6 input drops", 1, 8'h5C, 32'h0);
    rd("R7 sticky after input falls", 1, 8'h50, 32'h0000_0800);
    irq_chk("R7 irq stays", 1'b1);
    rd("R11 mstat read keeps", 1, 8'h50, 32'h0000_0800);

    wr(1, 8'h50, 32'h0000_0800);
    rd("R8 mstat clear", 1, 8'h50, 32'h0);
    irq_chk("R8 irq low after clear", 1'b0);

    wr(1, 8'h58, 32'hFFFF_FFFF); rd("R9 pol stored", 1, 8'h58, 32'hFFFF_FFFF);
    pulse(17'h00020, '0);
    rd("R9 latch unaffected", 1, 8'h50, 32'h0000_0800);
    irq_chk("R9 irq unaffected", 1'b1);
    wr(0, 8'h38, 32'hFFFF_FFFF);
    wr(1, 8'h50, 32'hFFFF_FFFF);
    rd("R9 cleared", 1, 8'h50, 32'h0);

    rd("R10 host hole", 0, 8'h24, 32'hFFFF_FFFF);
    rd("R10 master hole", 1, 8'h00, 32'hFFFF_FFFF);
    rd("R10 host past end", 0, 8'h44, 32'hFFFF_FFFF);
    wr(0, 8'h40, 32'h1234_5678); rd("R10 erraddr ro", 0, 8'h40, 32'h0);
    wr(1, 8'h5C, 32'hFFFF_FFFF); rd("R10 input ro", 1, 8'h5C, 32'h0);
    wr(0, 8'h3C, 32'h0);
    rd("R10 hole write mask", 0, 8'h34, 32'hFFFF_FFFF);
    rd("R10 hole write ctrl", 0, 8'h30, 32'h8000_0000);
    wr(1, 8'h04, 32'h0);
    rd("R10 hole write route0", 1, 8'h08, 32'hDEAD_BEEF);
    irq_chk("R10 irq untouched", 1'b0);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule